// File: doc/BRIEF.md
# Four-Output Motor-Control PWM Group

This block generates pulse-width-modulated switching patterns on four pins, arranged as two pairs. A shared timebase counts either upward with wrap-around (edge-aligned) or up to the period and back down (center-aligned). Each output is driven high while the counter is below that output's compare value. A pair can drive two independent waveforms, or one waveform and its exact inverse.

Software writes the period, four compare values and a mode word through a simple register write port. Every write lands in a shadow copy. The working copy takes the new values only at a permitted update point, so a pulse is never cut in the middle. In center-aligned operation a double-update option adds a second update point at the counter peak. This allows pulses that are not symmetric about the midpoint. A one-cycle strobe marks each period start and, in center-aligned mode, each peak. Controllers use the strobe to time their next write.

All pins are registered. They reflect the counter state of the previous clock cycle. The write port is a plain strobe with no handshake: a write is accepted in the cycle `wr_en` is high.

Top module: `pwm_quad_gen`

## Requirements
- R1: After reset, and on the clock edge after any cycle with `en` low, all four outputs and `period_strobe` are 0. While `en` is low the counter sits at 0 and the working registers follow the shadows, so the first cycle with `en` high begins a period using the most recent writes.
- R2: With mode bit 0 clear (edge-aligned), the counter runs 0,1,…,P-1 and wraps, where P is the working period. An output is high on the edge after a counter value below its compare value.
- R3: With mode bit 0 set (center-aligned), the counter runs 0,1,…,P,P-1,…,1 and repeats, which gives a period of 2P cycles. The high-while-below rule of R2 applies.
- R4: A compare value of 0 gives a constant low output. A compare value of P or more gives a constant high output in both alignments, including at the counter peak.
- R5: When a pair is paired (mode bit 2 for pins 0/1, mode bit 3 for pins 2/3), the even pin follows the compare value of that even pin and the odd pin is its exact inverse.
- R6: When a pair is not paired, each of its pins follows its own compare value.
- R7: Writes land in shadow registers. Period, mode and compare values reach the working set only when the counter returns to 0, or while `en` is low.
- R8: With mode bits 0 and 1 both set (double update), the compare values are also copied from the shadows when the counter reaches the peak P. Period and mode are not copied at that point.
- R9: `period_strobe` is high for one cycle after each cycle in which the counter is 0, and, in center-aligned mode, after each cycle in which the counter equals P.
- R10: Write address map: 0 period, 1 to 4 compare values of pins 0 to 3, 5 mode (bits 3:0). Writes to addresses 6 and 7 change nothing.
- R11: A period change takes effect at the next period start. With period 0 the counter stays at 0 and every cycle is a period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the group idle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 4 | PWM pins, two pairs (0/1 and 2/3) |
| period_strobe | output | 1 | One-cycle pulse at period start and center peak |

## Verification
The bench goes after several corner cases:
- The counter peak in center-aligned mode. A design that compared only "below" there would drop the high level of an output whose compare value equals the period.
- Compare values written mid-period. A design without shadowing would produce a truncated pulse.
- Writes made around the peak in double-update mode. A design that ignored the second update point would produce symmetric pulses where the model expects lopsided ones.
- Periods of 0 and 1, writes to unused addresses, and disabling mid-run. These expose wrap arithmetic that runs off the end, address decode that aliases, and idle states that leak stale levels to the pins.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int unsigned NUM_OUT  = 4;
  localparam int unsigned NUM_PAIR = NUM_OUT / 2;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned MODE_W   = NUM_PAIR + 2;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP0   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd5;

  // bit0 center, bit1 double update, bits 2+ paired flag per pair
  typedef struct packed {
    logic [NUM_PAIR-1:0] paired;
    logic                dbl_upd;
    logic                center;
  } mode_t;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [CNT_W-1:0]                wr_data,
  input  logic                            load_full,
  input  logic                            load_cmp,
  output logic [CNT_W-1:0]                act_period,
  output logic [NUM_OUT-1:0][CNT_W-1:0]   act_cmp,
  output mode_t                           act_mode
);
  logic [CNT_W-1:0]              sh_period;
  logic [NUM_OUT-1:0][CNT_W-1:0] sh_cmp;
  mode_t                         sh_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_period <= '0;
      sh_mode   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_PERIOD) sh_period <= wr_data;
      if (wr_addr == ADDR_MODE)   sh_mode   <= mode_t'(wr_data[MODE_W-1:0]);
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_CMP0 + ADDR_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sh_cmp[i] <= '0;
      else if (wr_en && wr_addr == MY_ADDR) sh_cmp[i] <= wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      act_cmp[i] <= '0;
      else if (load_full || load_cmp) act_cmp[i] <= sh_cmp[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_period <= '0;
      act_mode   <= '0;
    end else if (load_full) begin
      act_period <= sh_period;
      act_mode   <= sh_mode;
    end
  end
endmodule

// File: rtl/pwm_quad_timebase.sv
module pwm_quad_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  input  logic             center,
  input  logic             dbl_upd,
  output logic [CNT_W-1:0] cnt,
  output logic             at_start,
  output logic             at_peak,
  output logic             load_full,
  output logic             load_cmp
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             up;
  logic             nxt_up;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    nxt    = '0;
    nxt_up = 1'b1;
    if (center) begin
      if (up) begin
        if (cnt_inc >= {1'b0, period}) begin
          nxt    = period;
          nxt_up = 1'b0;
        end else begin
          nxt    = cnt_inc[CNT_W-1:0];
          nxt_up = 1'b1;
        end
      end else if (cnt <= ONE) begin
        nxt    = '0;
        nxt_up = 1'b1;
      end else begin
        nxt    = cnt - ONE;
        nxt_up = 1'b0;
      end
    end else begin
      nxt    = (cnt_inc >= {1'b0, period}) ? '0 : cnt_inc[CNT_W-1:0];
      nxt_up = 1'b1;
    end
  end

  assign load_full = !en || (nxt == '0);
  assign load_cmp  = en && center && dbl_upd && (nxt == period) && (nxt != '0);
  assign at_start  = (cnt == '0);
  assign at_peak   = center && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (!en) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= nxt;
      up  <= (nxt == '0) ? 1'b1 : nxt_up;
    end
  end
endmodule

// File: rtl/pwm_quad_pair.sv
module pwm_quad_pair #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             paired,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [1:0]       out
);
  function automatic logic level(input logic [CNT_W-1:0] c,
                                 input logic [CNT_W-1:0] p,
                                 input logic [CNT_W-1:0] k);
    if (c == '0)      return 1'b0;
    else if (c >= p)  return 1'b1;
    else              return k < c;
  endfunction

  logic lvl_a, lvl_b;
  assign lvl_a = level(cmp_a, period, cnt);
  assign lvl_b = paired ? ~lvl_a : level(cmp_b, period, cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   out <= 2'b00;
    else if (!en) out <= 2'b00;
    else          out <= {lvl_b, lvl_a};
  end
endmodule

// File: rtl/pwm_quad_gen.sv
module pwm_quad_gen
  import pwm_quad_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [CNT_W-1:0]      wr_data,
  output logic [NUM_OUT-1:0]    pwm_out,
  output logic                  period_strobe
);
  logic [CNT_W-1:0]              act_period;
  logic [NUM_OUT-1:0][CNT_W-1:0] act_cmp;
  mode_t                         act_mode;
  logic [CNT_W-1:0]              cnt;
  logic                          at_start, at_peak, load_full, load_cmp;

  pwm_quad_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_full(load_full), .load_cmp(load_cmp),
    .act_period(act_period), .act_cmp(act_cmp), .act_mode(act_mode)
  );

  pwm_quad_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en), .period(act_period),
    .center(act_mode.center), .dbl_upd(act_mode.dbl_upd),
    .cnt(cnt), .at_start(at_start), .at_peak(at_peak),
    .load_full(load_full), .load_cmp(load_cmp)
  );

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    pwm_quad_pair #(.CNT_W(CNT_W)) u_pair (
      .clk(clk), .rst_n(rst_n), .en(en), .paired(act_mode.paired[p]),
      .cnt(cnt), .period(act_period),
      .cmp_a(act_cmp[2*p]), .cmp_b(act_cmp[2*p+1]),
      .out(pwm_out[2*p+1:2*p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_strobe <= 1'b0;
    else        period_strobe <= en && (at_start || at_peak);
  end
endmodule

// File: rtl/pwm_quad_gen_chk.sv
module pwm_quad_gen_chk
  import pwm_quad_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          en,
  input logic [NUM_OUT-1:0]            pwm_out,
  input logic                          period_strobe,
  input logic [CNT_W-1:0]              cnt,
  input logic [CNT_W-1:0]              act_period,
  input logic [NUM_OUT-1:0][CNT_W-1:0] act_cmp,
  input mode_t                         act_mode,
  input logic                          load_full,
  input logic                          load_cmp
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_out == '0 && !period_strobe));

  a_r5_pair0_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_mode.paired[0]) |=> (pwm_out[1] == ~pwm_out[0]));

  a_r5_pair1_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_mode.paired[1]) |=> (pwm_out[3] == ~pwm_out[2]));

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_period);

  a_r2_edge_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !act_mode.center) |=> (cnt == '0 || cnt == $past(cnt) + CNT_W'(1)));

  a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (act_cmp == $past(act_cmp) || $past(load_full || load_cmp)));

  a_r9_strobe_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |-> $past(en));
endmodule

bind pwm_quad_gen pwm_quad_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwm_out(pwm_out), .period_strobe(period_strobe),
  .cnt(cnt), .act_period(act_period), .act_cmp(act_cmp), .act_mode(act_mode),
  .load_full(load_full), .load_cmp(load_cmp)
);

// File: tb/pwm_quad_gen_bench.sv
module pwm_quad_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [3:0]       pwm_out;
  logic             period_strobe;

  pwm_quad_gen #(.CNT_W(CNT_W)) u_pwm_quad_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .period_strobe(period_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0] pwm;
    logic       stb;
    string      tag;
  } exp_t;

  exp_t  sb_q[$];
  string phase = "R1";
  int    checks = 0;
  int    errors = 0;

  // reference model state
  int m_per, m_mode, m_cmp[4];
  int a_per, a_mode, a_cmp[4];
  int m_cnt;
  bit m_up;

  function automatic bit lvl(int c, int p, int k);
    if (c == 0) return 1'b0;
    if (c >= p) return 1'b1;
    return k < c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_per = 0; m_mode = 0; a_per = 0; a_mode = 0; m_cnt = 0; m_up = 1;
      for (int i = 0; i < 4; i++) begin m_cmp[i] = 0; a_cmp[i] = 0; end
      sb_q.delete();
    end else begin
      exp_t e;
      bit ctr, dbl, lf, lc, nup;
      int ncnt;
      ctr = a_mode[0]; dbl = a_mode[1];
      e.pwm = '0; e.stb = 1'b0; e.tag = phase;
      if (en) begin
        for (int p = 0; p < 2; p++) begin
          e.pwm[2*p]   = lvl(a_cmp[2*p], a_per, m_cnt);
          e.pwm[2*p+1] = a_mode[2+p] ? ~e.pwm[2*p] : lvl(a_cmp[2*p+1], a_per, m_cnt);
        end
        e.stb = (m_cnt == 0) || (ctr && m_cnt == a_per);
      end
      sb_q.push_back(e);
      if (!en) begin ncnt = 0; nup = 1; end
      else if (ctr) begin
        if (m_up) begin
          if (m_cnt + 1 >= a_per) begin ncnt = a_per; nup = 0; end
          else begin ncnt = m_cnt + 1; nup = 1; end
        end else if (m_cnt <= 1) begin ncnt = 0; nup = 1; end
        else begin ncnt = m_cnt - 1; nup = 0; end
      end else begin
        ncnt = (m_cnt + 1 >= a_per) ? 0 : m_cnt + 1; nup = 1;
      end
      lf = !en || ncnt == 0;
      lc = en && ctr && dbl && ncnt == a_per && ncnt != 0;
      if (ncnt == 0) nup = 1;
      if (lf) begin a_per = m_per; a_mode = m_mode; end
      if (lf || lc) for (int i = 0; i < 4; i++) a_cmp[i] = m_cmp[i];
      m_cnt = ncnt; m_up = nup;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_per = int'(wr_data);
          3'd1, 3'd2, 3'd3, 3'd4: m_cmp[int'(wr_addr) - 1] = int'(wr_data);
          3'd5: m_mode = int'(wr_data) & 15;
          default: ;
        endcase
      end
    end
  end

  // monitor: compare pins against the scoreboard away from the active edge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (pwm_out !== e.pwm || period_strobe !== e.stb) begin
        errors++;
        $display("FAIL %s: pwm_out=%b strobe=%b expected pwm_out=%b strobe=%b",
                 e.tag, pwm_out, period_strobe, e.pwm, e.stb);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=completion");
    finish_run();
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (pwm_out !== 4'b0 || period_strobe !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset: pwm_out=%b strobe=%b expected pwm_out=0000 strobe=0",
                 pwm_out, period_strobe);
      end
    end
    rst_n = 1'b1;

    phase = "R2 R4 R6 R10 edge-aligned";
    wr(0, 10); wr(1, 0); wr(2, 3); wr(3, 10); wr(4, 12); wr(5, 0);
    en = 1'b1;
    run(25);

    phase = "R7 shadowed compare";
    run(3); wr(2, 7); run(25);

    phase = "R5 paired pair0";
    wr(5, 4'b0100); wr(1, 4); run(30);

    phase = "R3 R4 R9 center-aligned";
    wr(0, 8); wr(1, 2); wr(2, 5); wr(3, 8); wr(4, 0); wr(5, 4'b0001);
    run(40);

    phase = "R8 double update";
    wr(5, 4'b0011);
    for (int i = 0; i < 6; i++) begin
      wr(1, i + 1); wr(3, 7 - i); run(5);
    end
    run(20);

    phase = "R11 R5 period change";
    wr(0, 5); wr(5, 4'b1001); run(30);

    phase = "R10 unused addresses";
    wr(6, 16'hffff); wr(7, 3); run(20);

    phase = "R4 R11 period one";
    wr(0, 1); wr(1, 0); wr(2, 1); wr(3, 2); wr(4, 1); wr(5, 0); run(10);
    phase = "R11 period zero edge";
    wr(0, 0); run(10);
    phase = "R11 period zero center";
    wr(5, 1); run(10);

    phase = "R1 disable and restart";
    wr(0, 6); run(10);
    en = 1'b0; run(5);
    wr(5, 4'b0010); wr(2, 4); en = 1'b1; run(30);

    run(2);
    finish_run();
  end
endmodule